// File: doc/BRIEF.md
# Two-Wire Configuration Write Slave

This block sits on a two-wire serial control bus and lets a host controller load a small bank of configuration registers in an audio control chip. The bus lines are oversampled by the system clock. The block detects start and stop conditions from the filtered lines and collects bytes. It acknowledges each accepted byte by enabling an open-drain pull-down on the data line during the ninth clock.

Each transfer begins with the chip address byte. A strap input picks one of two write addresses. Next comes a subaddress byte. Its low nibble selects a register and its top bit chooses between two modes. In one mode every data byte rewrites one register. In the other the register pointer steps forward after every data byte. Ten registers are implemented. Pointer codes above them are accepted on the bus, but the data sent to them is dropped. The register contents leave the block as one flat parallel vector. Register k occupies bits [8k+7:8k].

Top module: `cfgbus_slave`

## Requirements
- R1: A start condition (data line falling while the clock line is high) begins address reception from any state, including in the middle of a byte. A stop condition (data line rising while the clock line is high) returns the block to idle. Bytes clocked after a stop and before the next start get no acknowledge and write nothing.
- R2: With `addr_sel_i` = 0 the block answers to address byte 0x80, and with `addr_sel_i` = 1 to 0x82. An answered address byte is acknowledged.
- R3: Any other address byte, including one with bit 0 set, gets no acknowledge. No later byte of that transfer is acknowledged or stored.
- R4: In the subaddress byte, bits 3:0 form the register pointer, bit 7 selects the mode, and bits 6:4 have no effect. The subaddress byte is acknowledged.
- R5: With subaddress bit 7 = 0, every data byte of the transfer is written to the same selected register.
- R6: With subaddress bit 7 = 1, the pointer increases by one after each data byte, and it wraps from 15 to 0.
- R7: Data bytes whose pointer is 10 through 15 are acknowledged but change no register.
- R8: Register 0 holds the 6-bit attenuation code, and its bits 7:6 always read 0. Registers 1 to 9 hold all 8 bits.
- R9: After reset all registers read 0x00 and the data line is released.
- R10: The pull-down turns on only after the falling clock edge that ends the eighth bit, and turns off after the falling edge that ends the ninth clock. It is never on while a data bit is being clocked.
- R11: A register changes only when all eight bits of a data byte have been received. A byte cut short by a start or stop stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel_i | input | 1 | Strap: 0 selects write address 0x80, 1 selects 0x82 |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| regs_o | output | 80 | Register contents, register k at bits [8k+7:8k] |

## Verification
Two things happen in the same clock cycle: a data byte is stored and the register pointer is advanced. Crossing the end of the implemented range means that one update stores into register 9 and moves the pointer onto code 10, where discarding begins. Transfers that start at subaddress 0x88 and 0x8E provoke this, covering both the discard range and the wrap from 15 to 0. After the stop, every register is compared with a model that walks the same pointer sequence. Random transfers with random modes, start pointers and lengths then cross these boundaries many more times.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 4;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_SUB  = 2'd2,
        PH_DATA = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [3:0]          bit_cnt;
        logic [BYTE_W-2:0]   shreg;
        logic                ack_en;
        logic                oe;
        logic [PTR_W-1:0]    ptr;
        logic                inc;
        logic                wr_en;
        logic [PTR_W-1:0]    wr_ptr;
        logic [BYTE_W-1:0]   wr_data;
    } proto_st_t;
endpackage

// File: rtl/cfgbus_line_sync.sv
module cfgbus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.scl_pipe = {st_q.scl_pipe[STAGES-2:0], scl_i};
        st_d.sda_pipe = {st_q.sda_pipe[STAGES-2:0], sda_i};
        st_d.scl_prev = st_q.scl_pipe[STAGES-1];
        st_d.sda_prev = st_q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign scl_s     = st_q.scl_pipe[STAGES-1];
    assign sda_s     = st_q.sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~st_q.scl_prev;
    assign scl_fall  = ~scl_s & st_q.scl_prev;
    assign start_det = scl_s & st_q.scl_prev & st_q.sda_prev & ~sda_s;
    assign stop_det  = scl_s & st_q.scl_prev & ~st_q.sda_prev & sda_s;
endmodule

// File: rtl/cfgbus_proto.sv
module cfgbus_proto
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] dev_addr,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
    localparam logic [3:0] ACK_SLOT = 4'(BYTE_W);
    localparam logic [3:0] ACK_END  = 4'(BYTE_W + 1);

    proto_st_t         st_d, st_q;
    logic [BYTE_W-1:0] byte_v;
    logic              ptr_valid;

    assign byte_v    = {st_q.shreg, sda_s};
    assign ptr_valid = int'(st_q.ptr) < NUM_REGS;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        if (stop_det) begin
            st_d.phase   = PH_IDLE;
            st_d.oe      = 1'b0;
            st_d.bit_cnt = '0;
            st_d.ack_en  = 1'b0;
        end else if (start_det) begin
            st_d.phase   = PH_ADDR;
            st_d.oe      = 1'b0;
            st_d.bit_cnt = '0;
            st_d.ack_en  = 1'b0;
        end else if (st_q.phase != PH_IDLE) begin
            if (scl_rise && st_q.bit_cnt < ACK_SLOT) begin
                st_d.shreg   = byte_v[BYTE_W-2:0];
                st_d.bit_cnt = st_q.bit_cnt + 4'd1;
                if (st_q.bit_cnt == LAST_BIT) begin
                    unique case (st_q.phase)
                        PH_ADDR: begin
                            if (byte_v == dev_addr) begin
                                st_d.ack_en = 1'b1;
                                st_d.phase  = PH_SUB;
                            end else begin
                                st_d.ack_en = 1'b0;
                                st_d.phase  = PH_IDLE;
                            end
                        end
                        PH_SUB: begin
                            st_d.ptr    = byte_v[PTR_W-1:0];
                            st_d.inc    = byte_v[BYTE_W-1];
                            st_d.ack_en = 1'b1;
                            st_d.phase  = PH_DATA;
                        end
                        PH_DATA: begin
                            if (ptr_valid) begin
                                st_d.wr_en   = 1'b1;
                                st_d.wr_ptr  = st_q.ptr;
                                st_d.wr_data = byte_v;
                            end
                            if (st_q.inc) st_d.ptr = st_q.ptr + 1'b1;
                            st_d.ack_en = 1'b1;
                        end
                        default: st_d.ack_en = 1'b0;
                    endcase
                end
            end else if (scl_fall) begin
                if (st_q.bit_cnt == ACK_SLOT) begin
                    st_d.oe      = st_q.ack_en;
                    st_d.bit_cnt = ACK_END;
                end else if (st_q.bit_cnt == ACK_END) begin
                    st_d.oe      = 1'b0;
                    st_d.bit_cnt = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sda_oe  = st_q.oe;
    assign wr_en   = st_q.wr_en;
    assign wr_ptr  = st_q.wr_ptr;
    assign wr_data = st_q.wr_data;
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS  = 10,
    parameter int REG_W     = 8,
    parameter int ATTEN_IDX = 0,
    parameter int ATTEN_W   = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PTR_W-1:0]          wr_ptr,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        localparam int W = (k == ATTEN_IDX) ? ATTEN_W : REG_W;
        logic [W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (wr_en && wr_ptr == PTR_W'(k)) r_d = wr_data[W-1:0];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r_q <= '0;
            else        r_q <= r_d;
        end

        assign regs_o[k*REG_W +: REG_W] = REG_W'(r_q);
    end
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter int              NUM_REGS    = 10,
    parameter int              REG_W       = 8,
    parameter int              SYNC_STAGES = 2,
    parameter int              ATTEN_IDX   = 0,
    parameter int              ATTEN_W     = 6,
    parameter logic [BYTE_W-1:0] BASE_ADDR = 8'h80,
    parameter int              SEL_BIT     = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    input  logic                      addr_sel_i,
    output logic                      sda_oe_o,
    output logic [NUM_REGS*REG_W-1:0] regs_o
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] dev_addr;

    assign dev_addr = BASE_ADDR | (BYTE_W'(addr_sel_i) << SEL_BIT);

    cfgbus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgbus_proto #(.NUM_REGS(NUM_REGS)) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .dev_addr  (dev_addr),
        .sda_oe    (sda_oe_o),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data)
    );

    cfgbus_regbank #(
        .NUM_REGS  (NUM_REGS),
        .REG_W     (REG_W),
        .ATTEN_IDX (ATTEN_IDX),
        .ATTEN_W   (ATTEN_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (wr_data[REG_W-1:0]),
        .regs_o  (regs_o)
    );
endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS  = 10,
    parameter int REG_W     = 8,
    parameter int ATTEN_IDX = 0,
    parameter int ATTEN_W   = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      scl_s,
    input logic                      stop_det,
    input logic                      sda_oe,
    input logic                      wr_en,
    input logic [PTR_W-1:0]          wr_ptr,
    input logic [NUM_REGS*REG_W-1:0] regs
);
    // R11: the bank only moves in the cycle after a completed byte's strobe
    assert_regs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

    // R7: the strobe never targets an unimplemented pointer code
    assert_no_high_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_ptr) < NUM_REGS));

    // R1: a stop always releases the data line
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R10: the pull-down only turns on while the clock line is low
    assert_ack_in_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    if (ATTEN_W < REG_W) begin : g_atten
        // R8: the attenuation register keeps its upper bits clear
        assert_atten_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
            regs[ATTEN_IDX*REG_W + ATTEN_W +: (REG_W - ATTEN_W)] == '0);
    end
endmodule

bind cfgbus_slave cfgbus_slave_chk #(
    .NUM_REGS  (NUM_REGS),
    .REG_W     (REG_W),
    .ATTEN_IDX (ATTEN_IDX),
    .ATTEN_W   (ATTEN_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .stop_det (stop_det),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .regs     (regs_o)
);

// File: tb/cfgbus_slave_tb.sv
module cfgbus_slave_tb;
    localparam int NR = 10;
    localparam int Q  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_drv = 1'b1;
    logic addr_sel = 1'b0;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_regs [NR];
    logic [7:0] tx_data [8];
    bit oe_bad;

    assign sda_bus = sda_drv & ~sda_oe;

    always #2 clk = ~clk;

    cfgbus_slave u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_bus),
        .addr_sel_i (addr_sel),
        .sda_oe_o   (sda_oe),
        .regs_o     (regs)
    );

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dev_byte(input logic sel);
        return sel ? 8'h82 : 8'h80;
    endfunction

    task automatic wq;
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop;
        sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
    endtask

    task automatic send_bit(input logic b);
        sda_drv = b; wq(); scl = 1'b1; wq();
        if (sda_oe) oe_bad = 1'b1;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_drv = 1'b1; wq(); scl = 1'b1; wq();
        acked = sda_oe;
        wq(); scl = 1'b0; wq();
    endtask

    task automatic cmp_regs(input string req);
        for (int k = 0; k < NR; k++)
            chk(regs[k*8 +: 8] === exp_regs[k], req, regs[k*8 +: 8], exp_regs[k]);
    endtask

    // full write transfer; the model follows the requirement rules
    task automatic run_txn(input logic [7:0] a, input logic [7:0] sub, input int n, input string req);
        bit ack;
        bit match;
        logic [3:0] p;
        match = (a == dev_byte(addr_sel));
        oe_bad = 1'b0;
        bus_start();
        send_byte(a, ack);
        chk(ack == match, match ? "R2" : "R3", ack, match);
        send_byte(sub, ack);
        chk(ack == match, match ? "R4" : "R3", ack, match);
        p = sub[3:0];
        for (int i = 0; i < n; i++) begin
            send_byte(tx_data[i], ack);
            chk(ack == match, !match ? "R3" : (p >= 4'd10 ? "R7" : req), ack, match);
            if (match) begin
                if (p < 4'd10) exp_regs[p] = (p == 4'd0) ? (tx_data[i] & 8'h3F) : tx_data[i];
                if (sub[7]) p = p + 4'd1;
            end
        end
        bus_stop();
        repeat (4) @(posedge clk); #1;
        chk(!oe_bad && !sda_oe, "R10", {oe_bad, sda_oe}, 0);
        cmp_regs(req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        report();
    end

    initial begin
        bit ack;
        for (int k = 0; k < NR; k++) exp_regs[k] = 8'h00;
        repeat (5) @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk(regs === '0, "R9", regs[31:0], 0);
        chk(sda_oe === 1'b0, "R9", sda_oe, 0);

        // R5: single-register mode, last byte wins
        tx_data[0] = 8'h11; tx_data[1] = 8'h22; tx_data[2] = 8'h33;
        run_txn(8'h80, 8'h03, 3, "R5");
        // R6: auto-increment across 5..8
        tx_data[0] = 8'hA1; tx_data[1] = 8'hB2; tx_data[2] = 8'hC3; tx_data[3] = 8'hD4;
        run_txn(8'h80, 8'h85, 4, "R6");
        // R4: don't-care bits 6:4 set
        tx_data[0] = 8'h9C;
        run_txn(8'h80, 8'h72, 1, "R4");
        // R7: store into 8,9 then discard at 10,11
        tx_data[0] = 8'h5E; tx_data[1] = 8'h6F; tx_data[2] = 8'h77; tx_data[3] = 8'h88;
        run_txn(8'h80, 8'h88, 4, "R7");
        // R6 wrap 15->0, R8 masking of register 0
        tx_data[0] = 8'h01; tx_data[1] = 8'h02; tx_data[2] = 8'hFF; tx_data[3] = 8'h4D;
        run_txn(8'h80, 8'h8E, 4, "R6");
        tx_data[0] = 8'hC5;
        run_txn(8'h80, 8'h00, 1, "R8");
        // R3: wrong address / read bit
        tx_data[0] = 8'hEE; tx_data[1] = 8'hDD;
        run_txn(8'h82, 8'h81, 2, "R3");
        run_txn(8'h81, 8'h01, 1, "R3");
        // R2: strap high
        addr_sel = 1'b1;
        tx_data[0] = 8'h6A;
        run_txn(8'h82, 8'h06, 1, "R2");
        run_txn(8'h80, 8'h06, 1, "R3");
        addr_sel = 1'b0;

        // R11 and R1: byte cut by a repeated start stores nothing
        bus_start();
        send_byte(8'h80, ack);
        send_byte(8'h03, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'h80, ack);
        chk(ack, "R1", ack, 1);
        send_byte(8'h04, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        exp_regs[4] = 8'h5A;
        repeat (4) @(posedge clk); #1;
        cmp_regs("R11");

        // R1: bytes after a stop without a new start are ignored
        send_byte(8'h80, ack);
        chk(!ack, "R1", ack, 0);
        send_byte(8'h02, ack);
        chk(!ack, "R1", ack, 0);
        send_byte(8'hFF, ack);
        bus_stop();
        repeat (4) @(posedge clk); #1;
        cmp_regs("R1");

        // constrained random transfers
        void'($urandom(32'h5EED_C0DE));
        for (int t = 0; t < 40; t++) begin
            logic [7:0] a;
            int n;
            addr_sel = 1'($urandom_range(0, 1));
            a = dev_byte(addr_sel);
            if ($urandom_range(0, 9) == 0) a = a ^ 8'(1 << $urandom_range(0, 7));
            n = $urandom_range(1, 6);
            for (int i = 0; i < 8; i++) tx_data[i] = 8'($urandom);
            run_txn(a, 8'($urandom), n, "R6");
        end
        report();
    end
endmodule